// File: doc/BRIEF.md
# Chase Decision and Soft-Output Unit

This block closes one soft-in/soft-out decoding pass of a product-code turbo decoder. An upstream stage emits, for each corrected test vector, its hard-decision bits and one distance increment per symbol. The block sums those increments into a squared-Euclidean metric for each vector and stores the vector's bits. It ranks the vectors as they complete: the lowest metric becomes the decided word, and the next CW vectors are kept as competitors.

In the transmit phase, the caller presents the current soft input one symbol per clock, together with the iteration number. For each bit of the symbol the block derives the extrinsic value. That value comes from the metric gap to the best competitor that disagrees with the decision, or from a fixed reliability when no competitor disagrees. The block damps the extrinsic value by an iteration-dependent factor in quarter steps, adds it to the soft input, saturates the result and emits a new soft symbol one clock later. A `word_start` pulse opens a new word.

Top module: `chase_decide_out`

## Requirements
- R1: After reset, `y_valid` is 0, `dec_metric` is 4095, and every field of `cmp_metric` is 4095 (empty list).
- R2: The metric of a test vector is the sum of its N `dl_delta` values, saturated at 4095. The vector ends on the beat with `dl_last`=1. Vectors arrive with index 0, 1, 2, and so on, and the index is reported on `dec_idx`/`cmp_idx`.
- R3: `dec_idx`/`dec_metric` give the vector with the smallest metric. On equal metrics the lower index wins.
- R4: `cmp_idx`/`cmp_metric` field k (bits [k*3+:3] and [k*12+:12]) holds the (k+1)-th next-smallest metric, in ascending order, with ties going to the lower index.
- R5: Bit b of a symbol has a soft value at `x_soft[b*5+:5]` (signed two's complement), and hard bit 1 corresponds to a positive soft value. Take the first competitor in rank order whose bit b differs from the decided bit d. The extrinsic value is W = s*((Mc-Md)>>2) - R, where s = +1 if d=1 and s = -1 if d=0.
- R6: If no competitor differs at that bit, W = +15 for d=1 and W = -15 for d=0.
- R7: The damping code for iteration i is taken from the table {1,2,2,3,3,4,4,4} for i = 0..7. The damped value is floor(W*code/4).
- R8: The output soft value is R + damped W, saturated to the range [-16, 15]. It is placed at the same bit field as the input.
- R9: `y_valid`/`y_soft` follow a beat with `x_valid`=1 by exactly one clock. Symbols are counted from 0 after `word_start`. `y_valid` is 0 in every other cycle.
- R10: `word_start` empties the ranked list (`dec_metric` returns to 4095) and restarts the vector and symbol counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_start | input | 1 | Begin a new word |
| dl_valid | input | 1 | Distance beat valid |
| dl_last | input | 1 | Last symbol of current test vector |
| dl_delta | input | 9 | Per-symbol distance increment |
| dl_bits | input | 4 | Hard bits of the test vector symbol |
| x_valid | input | 1 | Soft-input symbol valid |
| x_iter | input | 3 | Iteration number, selects damping |
| x_soft | input | 20 | Soft input symbol, four 5-bit values |
| y_valid | output | 1 | Soft output valid |
| y_soft | output | 20 | Soft output symbol |
| dec_idx | output | 3 | Decided test-vector index |
| dec_metric | output | 12 | Decided metric |
| cmp_idx | output | 9 | Competitor indices, rank order |
| cmp_metric | output | 36 | Competitor metrics, rank order |

## Verification
The bench feeds four kinds of word and compares every beat against a behavioural model. Small random increments with random bits exercise the normal ranking and the metric-gap extrinsic path. Identical increments make all metrics equal, which separates the tie rule from a plain minimum search and drives the metric gap to zero. Identical bits across all vectors force the fixed-reliability path, with extreme soft inputs that reach both saturation limits. Large increments push several metrics to the 4095 ceiling, which tests metric saturation together with ties. Every iteration number is used, so each damping code is exercised.

// File: rtl/chase_pkg.sv
package chase_pkg;
  // damping is expressed in quarters
  localparam int ALPHA_SHIFT = 2;
  // metric gap is divided by four before use
  localparam int GAP_SHIFT = 2;
endpackage

// File: rtl/cds_metric_acc.sv
module cds_metric_acc #(
  parameter int N  = 15,
  parameter int M  = 4,
  parameter int TV = 8,
  parameter int K  = 4,
  parameter int MW = 12,
  parameter int DW = 9,
  localparam int TW = $clog2(TV),
  localparam int SW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            dl_valid,
  input  logic            dl_last,
  input  logic [DW-1:0]   dl_delta,
  input  logic [M-1:0]    dl_bits,
  input  logic [K*TW-1:0] rd_idx,
  input  logic [SW-1:0]   rd_sym,
  output logic [K*M-1:0]  rd_bits,
  output logic            ins_valid,
  output logic [MW-1:0]   ins_met,
  output logic [TW-1:0]   ins_idx
);
  localparam int DEPTH = TV << SW;

  logic [M-1:0]  cand_mem [DEPTH];
  logic [MW-1:0] acc;
  logic [TW-1:0] tv_cnt;
  logic [SW-1:0] sym_cnt;
  logic [MW:0]   sum;
  logic [MW-1:0] tot;

  assign sum = {1'b0, acc} + {{(MW+1-DW){1'b0}}, dl_delta};
  assign tot = sum[MW] ? {MW{1'b1}} : sum[MW-1:0];

  assign ins_valid = dl_valid && dl_last && !start;
  assign ins_met   = tot;
  assign ins_idx   = tv_cnt;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc     <= '0;
      tv_cnt  <= '0;
      sym_cnt <= '0;
    end else if (dl_valid) begin
      if (dl_last) begin
        acc     <= '0;
        sym_cnt <= '0;
        tv_cnt  <= tv_cnt + 1'b1;
      end else begin
        acc     <= tot;
        sym_cnt <= sym_cnt + 1'b1;
      end
    end
  end

  // candidate bits, one write port
  always_ff @(posedge clk) begin
    if (dl_valid && !start)
      cand_mem[{tv_cnt, sym_cnt}] <= dl_bits;
  end

  generate
    for (genvar k = 0; k < K; k++) begin : g_rd
      assign rd_bits[k*M +: M] = cand_mem[{rd_idx[k*TW +: TW], rd_sym}];
    end
  endgenerate

  // R2
  acc_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (dl_valid && !dl_last && !start) |=> (acc >= $past(acc)));
  // R2
  sym_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_cnt < SW'(N)));
endmodule

// File: rtl/cds_rank.sv
module cds_rank #(
  parameter int TV = 8,
  parameter int K  = 4,
  parameter int MW = 12,
  localparam int TW = $clog2(TV)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            ins_valid,
  input  logic [MW-1:0]   ins_met,
  input  logic [TW-1:0]   ins_idx,
  output logic [K*MW-1:0] met_o,
  output logic [K*TW-1:0] idx_o,
  output logic [K-1:0]    vld_o
);
  logic [MW-1:0] met [K];
  logic [TW-1:0] idx [K];
  logic [K-1:0]  vld;
  logic [K-1:0]  lt;
  logic [K-1:0]  put;

  // strict compare: equal metric keeps the earlier, lower index ahead
  generate
    for (genvar k = 0; k < K; k++) begin : g_cmp
      assign lt[k] = !vld[k] || (ins_met < met[k]);
      if (k == 0) begin : g_first
        assign put[k] = lt[k];
      end else begin : g_rest
        assign put[k] = lt[k] && !lt[k-1];
      end
      assign met_o[k*MW +: MW] = met[k];
      assign idx_o[k*TW +: TW] = idx[k];
    end
  endgenerate
  assign vld_o = vld;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      for (int k = 0; k < K; k++) begin
        met[k] <= '1;
        idx[k] <= '0;
      end
      vld <= '0;
    end else if (ins_valid) begin
      for (int k = 0; k < K; k++) begin
        if (put[k]) begin
          met[k] <= ins_met;
          idx[k] <= ins_idx;
          vld[k] <= 1'b1;
        end else if (k > 0 && lt[k-1]) begin
          met[k] <= met[k-1];
          idx[k] <= idx[k-1];
          vld[k] <= vld[k-1];
        end
      end
    end
  end

  // R3
  one_slot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(put));
  // R4
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (vld[1] |-> (met[0] <= met[1])));
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (vld == '0));
endmodule

// File: rtl/cds_soft_bit.sv
module cds_soft_bit
  import chase_pkg::*;
#(
  parameter int K    = 4,
  parameter int MW   = 12,
  parameter int Q    = 5,
  parameter int AW   = 3,
  parameter int BETA = 15
) (
  input  logic [K-1:0]      d_bits,
  input  logic [K-1:0]      vld,
  input  logic [K*MW-1:0]   met,
  input  logic [AW-1:0]     alpha,
  input  logic signed [Q-1:0] r_in,
  output logic signed [Q-1:0] r_out
);
  localparam int WW = MW + 2;
  localparam int PW = WW + AW + 1;
  localparam logic signed [PW-1:0] QMAX = PW'((1 << (Q-1)) - 1);
  localparam logic signed [PW-1:0] QMIN = -PW'(1 << (Q-1));
  localparam logic signed [WW-1:0] BETA_W = WW'(BETA);

  logic              found;
  logic [MW-1:0]     gap;
  logic signed [WW-1:0] magx, rx, w;
  logic signed [PW-1:0] pw, prod, scaled, sum;

  always_comb begin
    found = 1'b0;
    gap   = '0;
    // walk from the back so the best-ranked disagreeing competitor wins
    for (int k = K-1; k >= 1; k--) begin
      if (vld[k] && (d_bits[k] != d_bits[0])) begin
        found = 1'b1;
        gap   = met[k*MW +: MW] - met[0 +: MW];
      end
    end
    magx = WW'(gap >> GAP_SHIFT);
    rx   = WW'(r_in);
    if (found)
      w = d_bits[0] ? (magx - rx) : (-magx - rx);
    else
      w = d_bits[0] ? BETA_W : -BETA_W;
    pw   = PW'(w);
    prod = '0;
    for (int i = 0; i < AW; i++)
      if (alpha[i]) prod = prod + (pw <<< i);
    scaled = prod >>> ALPHA_SHIFT;
    sum    = scaled + PW'(r_in);
    if (sum > QMAX)      r_out = QMAX[Q-1:0];
    else if (sum < QMIN) r_out = QMIN[Q-1:0];
    else                 r_out = sum[Q-1:0];
  end
endmodule

// File: rtl/chase_decide_out.sv
module chase_decide_out #(
  parameter int N     = 15,
  parameter int M     = 4,
  parameter int Q     = 5,
  parameter int TV    = 8,
  parameter int CW    = 3,
  parameter int MW    = 12,
  parameter int DW    = 9,
  parameter int NITER = 8,
  parameter int AW    = 3,
  parameter int BETA  = 15,
  parameter logic [NITER*AW-1:0] ALPHA_TAB =
    {3'd4, 3'd4, 3'd4, 3'd3, 3'd3, 3'd2, 3'd2, 3'd1},
  localparam int TW = $clog2(TV),
  localparam int IW = $clog2(NITER),
  localparam int K  = CW + 1,
  localparam int SW = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_start,
  input  logic             dl_valid,
  input  logic             dl_last,
  input  logic [DW-1:0]    dl_delta,
  input  logic [M-1:0]     dl_bits,
  input  logic             x_valid,
  input  logic [IW-1:0]    x_iter,
  input  logic [M*Q-1:0]   x_soft,
  output logic             y_valid,
  output logic [M*Q-1:0]   y_soft,
  output logic [TW-1:0]    dec_idx,
  output logic [MW-1:0]    dec_metric,
  output logic [CW*TW-1:0] cmp_idx,
  output logic [CW*MW-1:0] cmp_metric
);
  logic [K*MW-1:0] l_met;
  logic [K*TW-1:0] l_idx;
  logic [K-1:0]    l_vld;
  logic [K*M-1:0]  rd_bits;
  logic            ins_valid;
  logic [MW-1:0]   ins_met;
  logic [TW-1:0]   ins_idx;
  logic [SW-1:0]   ox_sym;
  logic [AW-1:0]   alpha;
  logic [M*Q-1:0]  soft_nxt;

  cds_metric_acc #(.N(N), .M(M), .TV(TV), .K(K), .MW(MW), .DW(DW)) u_acc (
    .clk(clk), .rst(rst), .start(word_start),
    .dl_valid(dl_valid), .dl_last(dl_last), .dl_delta(dl_delta), .dl_bits(dl_bits),
    .rd_idx(l_idx), .rd_sym(ox_sym), .rd_bits(rd_bits),
    .ins_valid(ins_valid), .ins_met(ins_met), .ins_idx(ins_idx)
  );

  cds_rank #(.TV(TV), .K(K), .MW(MW)) u_rank (
    .clk(clk), .rst(rst), .start(word_start),
    .ins_valid(ins_valid), .ins_met(ins_met), .ins_idx(ins_idx),
    .met_o(l_met), .idx_o(l_idx), .vld_o(l_vld)
  );

  assign alpha = ALPHA_TAB[x_iter*AW +: AW];

  generate
    for (genvar b = 0; b < M; b++) begin : g_bit
      logic [K-1:0] col;
      for (genvar k = 0; k < K; k++) begin : g_col
        assign col[k] = rd_bits[k*M + b];
      end
      cds_soft_bit #(.K(K), .MW(MW), .Q(Q), .AW(AW), .BETA(BETA)) u_sb (
        .d_bits(col), .vld(l_vld), .met(l_met), .alpha(alpha),
        .r_in(x_soft[b*Q +: Q]), .r_out(soft_nxt[b*Q +: Q])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
      y_soft  <= '0;
      ox_sym  <= '0;
    end else begin
      y_valid <= x_valid && !word_start;
      if (word_start) begin
        ox_sym <= '0;
      end else if (x_valid) begin
        y_soft <= soft_nxt;
        ox_sym <= (ox_sym == SW'(N-1)) ? '0 : ox_sym + 1'b1;
      end
    end
  end

  assign dec_idx    = l_idx[0 +: TW];
  assign dec_metric = l_met[0 +: MW];
  assign cmp_idx    = l_idx[K*TW-1:TW];
  assign cmp_metric = l_met[K*MW-1:MW];

  // R9
  out_follow_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> $past(x_valid));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !x_valid |=> $stable(y_soft));
endmodule

// File: tb/chase_decide_out_bench.sv
module chase_decide_out_bench;
  localparam int N = 15, M = 4, Q = 5, TV = 8, CW = 3, MW = 12, DW = 9;
  localparam int TW = 3, IW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, word_start, dl_valid, dl_last, x_valid;
  logic [DW-1:0] dl_delta;
  logic [M-1:0] dl_bits;
  logic [IW-1:0] x_iter;
  logic [M*Q-1:0] x_soft, y_soft;
  logic y_valid;
  logic [TW-1:0] dec_idx;
  logic [MW-1:0] dec_metric;
  logic [CW*TW-1:0] cmp_idx;
  logic [CW*MW-1:0] cmp_metric;

  chase_decide_out u_chase_decide_out (
    .clk(clk), .rst(rst), .word_start(word_start), .dl_valid(dl_valid),
    .dl_last(dl_last), .dl_delta(dl_delta), .dl_bits(dl_bits),
    .x_valid(x_valid), .x_iter(x_iter), .x_soft(x_soft),
    .y_valid(y_valid), .y_soft(y_soft), .dec_idx(dec_idx),
    .dec_metric(dec_metric), .cmp_idx(cmp_idx), .cmp_metric(cmp_metric)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int dlt [TV][N];
  logic [M-1:0] cb [TV][N];
  int met [TV];
  int ord [TV];
  int alpha_tab [8] = '{1, 2, 2, 3, 3, 4, 4, 4};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic void rank_model();
    bit used [TV];
    for (int t = 0; t < TV; t++) begin
      used[t] = 0;
      met[t] = 0;
      for (int j = 0; j < N; j++) met[t] += dlt[t][j];
      if (met[t] > 4095) met[t] = 4095;
    end
    for (int p = 0; p < TV; p++) begin
      int best = -1;
      for (int t = 0; t < TV; t++)
        if (!used[t] && (best < 0 || met[t] < met[best])) best = t;
      ord[p] = best;
      used[best] = 1;
    end
  endfunction

  function automatic logic [M*Q-1:0] exp_soft(int s, int it, logic [M*Q-1:0] xs);
    logic [M*Q-1:0] res;
    for (int b = 0; b < M; b++) begin
      int d, r, w, o, gapv;
      bit found = 0;
      logic signed [Q-1:0] rv;
      d = cb[ord[0]][s][b];
      rv = xs[b*Q +: Q];
      r = rv;
      gapv = 0;
      for (int k = 1; k <= CW; k++)
        if (!found && cb[ord[k]][s][b] != d) begin
          found = 1;
          gapv = (met[ord[k]] - met[ord[0]]) / 4;
        end
      if (found) w = (d ? gapv : -gapv) - r;
      else w = d ? 15 : -15;
      o = r + ((w * alpha_tab[it]) >>> 2);
      if (o > 15) o = 15;
      if (o < -16) o = -16;
      res[b*Q +: Q] = o[Q-1:0];
    end
    return res;
  endfunction

  // mode 0 random small, 1 all equal, 2 same bits everywhere, 3 large
  task automatic load_word(int mode);
    logic [M-1:0] common [N];
    for (int j = 0; j < N; j++) common[j] = M'($urandom);
    for (int t = 0; t < TV; t++)
      for (int j = 0; j < N; j++) begin
        case (mode)
          0: dlt[t][j] = $urandom_range(0, 40);
          1: dlt[t][j] = 5;
          2: dlt[t][j] = $urandom_range(0, 60);
          default: dlt[t][j] = (t % 3 == 0) ? 511 : $urandom_range(150, 300);
        endcase
        cb[t][j] = (mode == 2) ? common[j] : M'($urandom);
      end
    rank_model();
    @(negedge clk);
    word_start = 1;
    @(negedge clk);
    word_start = 0;
    chk("R10 list cleared", int'(dec_metric), 4095);
    for (int t = 0; t < TV; t++)
      for (int j = 0; j < N; j++) begin
        dl_valid = 1;
        dl_last  = (j == N-1);
        dl_delta = DW'(dlt[t][j]);
        dl_bits  = cb[t][j];
        @(negedge clk);
      end
    dl_valid = 0;
    dl_last  = 0;
    chk("R3 decided idx", int'(dec_idx), ord[0]);
    chk("R2 decided metric", int'(dec_metric), met[ord[0]]);
    for (int k = 0; k < CW; k++) begin
      chk("R4 competitor idx", int'(cmp_idx[k*TW +: TW]), ord[k+1]);
      chk("R4 competitor metric", int'(cmp_metric[k*MW +: MW]), met[ord[k+1]]);
    end
  endtask

  task automatic send_word(int mode, string tag);
    for (int s = 0; s < N; s++) begin
      logic [M*Q-1:0] xs;
      int it;
      it = $urandom_range(0, 7);
      for (int b = 0; b < M; b++) begin
        if (mode == 1) xs[b*Q +: Q] = ($urandom_range(0, 1) != 0) ? 5'd15 : 5'h10;
        else xs[b*Q +: Q] = Q'($urandom);
      end
      @(negedge clk);
      x_valid = 1;
      x_iter  = IW'(it);
      x_soft  = xs;
      @(posedge clk);
      #1;
      chk("R9 y_valid", int'(y_valid), 1);
      chk(tag, int'(y_soft), int'(exp_soft(s, it, xs)));
    end
    @(negedge clk);
    x_valid = 0;
    @(posedge clk);
    #1;
    chk("R9 y_valid idle", int'(y_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst = 1; word_start = 0; dl_valid = 0; dl_last = 0; dl_delta = '0;
    dl_bits = '0; x_valid = 0; x_iter = '0; x_soft = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 y_valid reset", int'(y_valid), 0);
    chk("R1 dec_metric reset", int'(dec_metric), 4095);
    chk("R1 cmp_metric reset", int'(cmp_metric == '1), 1);
    for (int rep = 0; rep < 3; rep++) begin
      load_word(0);
      send_word(0, "R5 R7 R8 soft out random");
    end
    load_word(1);
    send_word(0, "R5 R8 soft out tied metrics");
    load_word(2);
    send_word(1, "R6 R8 soft out beta saturated");
    load_word(2);
    send_word(0, "R6 R7 soft out beta");
    load_word(3);
    send_word(1, "R2 R5 R8 soft out large metrics");
    summary();
  end
endmodule